// File: doc/BRIEF.md
# Clock Source Control and Gating Unit

This block holds the configuration of a clock generator and turns it into control signals. Software writes three small registers through a simple write/read port. They hold a bus divider select, a low-power bit, a reference range select, enable and stop-retention bits for the internal and external reference clocks, and a coarse and a fine trim code. The block has no oscillator or frequency loop of its own. It drives their controls: a loop enable, a trim code, and glitch-free gates on the two reference clocks that it receives from outside.

The operating mode arrives as a 3-bit code. The block decodes it without a clock to decide three things: whether the frequency loop stays enabled, which reference clocks keep running while the stop input is high, and whether the trim code reaches the main output clock. Two resets are kept apart. The power-on reset clears everything. The system reset clears the control register but leaves the trim codes as they are.

Top module: `clk_ctrl_unit`

## Requirements
- R1: The bus divider field is control bits [1:0] (0 gives divide by 1, 1 by 2, 2 by 4, 3 by 8). A write to it appears on bus_div_o in the cycle after the write edge, whatever else is configured.
- R2: Control bit 3 is the range select. A write to it is ignored while the stored low-power bit (control bit 2) is 1, including the write that clears the low-power bit. It is accepted once the stored bit is 0.
- R3: Mode codes are FEI=0, FEE=1, FBI=2, FBE=3, PEE=4, PBE=5, BLPI=6 and BLPE=7. loop_en_o is 1 in modes 0, 1 and 4. In modes 2, 3 and 5 it equals the inverse of the low-power bit. In modes 6 and 7 it is 0.
- R4: Control bit 4 enables the internal reference. With stop_i low, irc_en_o equals that bit, and irc_clk_o toggles only while it is set.
- R5: With stop_i high, irc_en_o is 1 only when both control bit 5 (internal stop-enable) and bit 4 are set.
- R6: Control bit 6 enables the external reference and bit 7 is its stop-enable. With stop_i low, erc_en_o equals bit 6. With stop_i high, erc_en_o is 1 when bits 6 and 7 are both set, or when the mode is 1, 3, 4, 5 or 7. erc_clk_o toggles only while erc_en_o is 1.
- R7: The coarse trim (address 1, 8 bits) and the fine trim (address 2, bit 0) are cleared only by por_ni, to 0x80 and 0. A rst_ni pulse clears the control register (address 0) to 0x00 and leaves both trim codes unchanged.
- R8: trim_o carries {coarse, fine}. trim_act_o is 1 exactly in modes 0, 2 and 6.
- R9: Reading addresses 0, 1 and 2 returns the stored control, coarse trim and fine trim. Unused bits and address 3 read as 0. After power-on reset the reads return 0x00, 0x80 and 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| mode_i | input | 3 | Current operating mode code |
| stop_i | input | 1 | Stop mode active |
| irc_src_i | input | 1 | Internal reference oscillator clock |
| erc_src_i | input | 1 | External reference oscillator clock |
| irc_clk_o | output | 1 | Gated internal reference clock |
| erc_clk_o | output | 1 | Gated external reference clock |
| irc_en_o | output | 1 | Internal reference gate enable |
| erc_en_o | output | 1 | External reference gate enable |
| bus_div_o | output | 2 | Bus divider select |
| range_o | output | 1 | Reference range select |
| loop_en_o | output | 1 | Frequency loop enable |
| trim_o | output | 9 | Coarse and fine trim to the oscillator |
| trim_act_o | output | 1 | Trim affects the main output clock |

## Verification
A wrong stored field shows on rd_data_o and on the decoded enables one cycle after the write that caused it. The sweep covers every mode against every combination of low-power, stop and enable bits, so a wrong decode term shows as a mismatch on loop_en_o, irc_en_o or erc_en_o at a sample point. Errors in the range interlock or in reset domains show only through the sequence order. A range bit that was accepted too early, or a trim code cleared by the system reset, appears on the first read after that step.

// File: rtl/clk_ctrl_pkg.sv
package clk_ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_TRIM  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FTRIM = 2'd2;

  typedef enum logic [2:0] {
    M_FEI  = 3'd0,
    M_FEE  = 3'd1,
    M_FBI  = 3'd2,
    M_FBE  = 3'd3,
    M_PEE  = 3'd4,
    M_PBE  = 3'd5,
    M_BLPI = 3'd6,
    M_BLPE = 3'd7
  } mode_e;

  typedef struct packed {
    logic       erc_sten;
    logic       erc_en;
    logic       irc_sten;
    logic       irc_en;
    logic       range;
    logic       lp;
    logic [1:0] bdiv;
  } ctrl_t;
endpackage

// File: rtl/clk_ctrl_regs.sv
module clk_ctrl_regs
  import clk_ctrl_pkg::*;
#(
  parameter int          TRIM_W   = 8,
  parameter logic [TRIM_W-1:0] TRIM_RST = 8'h80
) (
  input  logic                clk_i,
  input  logic                por_ni,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output ctrl_t               ctrl_o,
  output logic [TRIM_W-1:0]   coarse_o,
  output logic                fine_o
);
  logic  sys_rst_n;
  ctrl_t ctrl_q, wr_ctrl;

  assign sys_rst_n = rst_ni & por_ni;
  assign wr_ctrl   = ctrl_t'(wr_data_i);

  always_ff @(posedge clk_i or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en_i && wr_addr_i == ADDR_CTRL) begin
      ctrl_q.bdiv     <= wr_ctrl.bdiv;
      ctrl_q.lp       <= wr_ctrl.lp;
      ctrl_q.irc_en   <= wr_ctrl.irc_en;
      ctrl_q.irc_sten <= wr_ctrl.irc_sten;
      ctrl_q.erc_en   <= wr_ctrl.erc_en;
      ctrl_q.erc_sten <= wr_ctrl.erc_sten;
      // range locked while stored lp is set
      if (!ctrl_q.lp) ctrl_q.range <= wr_ctrl.range;
    end
  end

  // trim lives in the power-on domain only
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      coarse_o <= TRIM_RST;
      fine_o   <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADDR_TRIM)  coarse_o <= wr_data_i[TRIM_W-1:0];
      if (wr_addr_i == ADDR_FTRIM) fine_o   <= wr_data_i[0];
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      ADDR_CTRL:  rd_data_o = DATA_W'(ctrl_q);
      ADDR_TRIM:  rd_data_o = DATA_W'(coarse_o);
      ADDR_FTRIM: rd_data_o = DATA_W'(fine_o);
      default:    rd_data_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;

  a_r2_range_locked: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    ctrl_q.lp |=> $stable(ctrl_q.range));

  a_r7_trim_por_only: assert property (@(posedge clk_i) disable iff (!por_ni)
    !(wr_en_i && wr_addr_i == ADDR_TRIM) |=> $stable(coarse_o));

  a_r1_bdiv_follows: assert property (@(posedge clk_i) disable iff (!sys_rst_n)
    (wr_en_i && wr_addr_i == ADDR_CTRL) |=> ctrl_q.bdiv == $past(wr_data_i[1:0]));
endmodule

// File: rtl/clk_ctrl_decode.sv
module clk_ctrl_decode
  import clk_ctrl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  stop_i,
  input  ctrl_t ctrl_i,
  output logic  loop_en_o,
  output logic  irc_run_o,
  output logic  erc_run_o,
  output logic  trim_act_o
);
  logic engaged, bypassed, ext_mode;

  always_comb begin
    engaged    = mode_i inside {M_FEI, M_FEE, M_PEE};
    bypassed   = mode_i inside {M_FBI, M_FBE, M_PBE};
    ext_mode   = mode_i inside {M_FEE, M_FBE, M_PEE, M_PBE, M_BLPE};
    trim_act_o = mode_i inside {M_FEI, M_FBI, M_BLPI};
  end

  assign loop_en_o = engaged | (bypassed & ~ctrl_i.lp);
  assign irc_run_o = ctrl_i.irc_en & (~stop_i | ctrl_i.irc_sten);
  assign erc_run_o = stop_i ? ((ctrl_i.erc_en & ctrl_i.erc_sten) | ext_mode)
                            : ctrl_i.erc_en;

  a_r3_loop_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {M_FBI, M_FBE, M_PBE}) && !ctrl_i.lp |-> loop_en_o);

  a_r5_irc_stop_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !ctrl_i.irc_sten |-> !irc_run_o);

  a_r6_erc_ext_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && (mode_i inside {M_FEE, M_FBE, M_PEE, M_PBE, M_BLPE}) |-> erc_run_o);
endmodule

// File: rtl/clk_ctrl_gate.sv
module clk_ctrl_gate (
  input  logic src_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_l;

  // transparent while source is low: enable moves only between pulses
  always_latch begin
    if (!src_i) en_l <= en_i;
  end

  assign gclk_o = src_i & en_l;
endmodule

// File: rtl/clk_ctrl_unit.sv
module clk_ctrl_unit
  import clk_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       por_ni,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [1:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  input  logic [2:0] mode_i,
  input  logic       stop_i,
  input  logic       irc_src_i,
  input  logic       erc_src_i,
  output logic       irc_clk_o,
  output logic       erc_clk_o,
  output logic       irc_en_o,
  output logic       erc_en_o,
  output logic [1:0] bus_div_o,
  output logic       range_o,
  output logic       loop_en_o,
  output logic [8:0] trim_o,
  output logic       trim_act_o
);
  localparam int TRIM_W = 8;

  ctrl_t             ctrl;
  logic [TRIM_W-1:0] coarse;
  logic              fine;
  logic              sys_rst_n;

  assign sys_rst_n = rst_ni & por_ni;

  clk_ctrl_regs #(.TRIM_W(TRIM_W), .TRIM_RST(8'h80)) i_regs (
    .clk_i     (clk_i),
    .por_ni    (por_ni),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .ctrl_o    (ctrl),
    .coarse_o  (coarse),
    .fine_o    (fine)
  );

  clk_ctrl_decode i_decode (
    .clk_i      (clk_i),
    .rst_ni     (sys_rst_n),
    .mode_i     (mode_e'(mode_i)),
    .stop_i     (stop_i),
    .ctrl_i     (ctrl),
    .loop_en_o  (loop_en_o),
    .irc_run_o  (irc_en_o),
    .erc_run_o  (erc_en_o),
    .trim_act_o (trim_act_o)
  );

  clk_ctrl_gate i_irc_gate (.src_i(irc_src_i), .en_i(irc_en_o), .gclk_o(irc_clk_o));
  clk_ctrl_gate i_erc_gate (.src_i(erc_src_i), .en_i(erc_en_o), .gclk_o(erc_clk_o));

  assign bus_div_o = ctrl.bdiv;
  assign range_o   = ctrl.range;
  assign trim_o    = {coarse, fine};
endmodule

// File: tb/test_clk_ctrl_unit.sv
module test_clk_ctrl_unit;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, por_n = 0, rst_n = 1;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [2:0] mode = 0;
  logic stop = 0, irc_src = 0, erc_src = 0;
  logic irc_clk, erc_clk, irc_en, erc_en, range, loop_en, trim_act;
  logic [1:0] bus_div;
  logic [8:0] trim;
  int checks = 0, errors = 0;
  int irc_cnt = 0, erc_cnt = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #4ns irc_src = ~irc_src;
  always #7ns erc_src = ~erc_src;
  always @(posedge irc_clk) irc_cnt++;
  always @(posedge erc_clk) erc_cnt++;

  clk_ctrl_unit i_clk_ctrl_unit (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .mode_i(mode), .stop_i(stop), .irc_src_i(irc_src), .erc_src_i(erc_src),
    .irc_clk_o(irc_clk), .erc_clk_o(erc_clk), .irc_en_o(irc_en), .erc_en_o(erc_en),
    .bus_div_o(bus_div), .range_o(range), .loop_en_o(loop_en),
    .trim_o(trim), .trim_act_o(trim_act)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, int exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    // R9 reset values
    rd_chk("R9 ctrl rst", 0, 8'h00);
    rd_chk("R9 trim rst", 1, 8'h80);
    rd_chk("R9 ftrim rst", 2, 8'h00);
    rd_chk("R9 addr3", 3, 8'h00);

    // R1 bus divider
    for (int d = 0; d < 4; d++) begin
      wr(0, 8'(d) | 8'h50);
      chk("R1 bus_div", bus_div, d);
    end

    // R2 range interlock sequence
    wr(0, 8'h04);
    chk("R2 lp set range 0", range, 0);
    wr(0, 8'h0C);
    chk("R2 range ignored lp=1", range, 0);
    rd_chk("R2 readback", 0, 8'h04);
    wr(0, 8'h08);
    chk("R2 ignored on lp clear", range, 0);
    wr(0, 8'h08);
    chk("R2 accepted lp=0", range, 1);
    wr(0, 8'h0C);
    chk("R2 set with lp", range, 1);
    wr(0, 8'h00);
    chk("R2 locked at 1", range, 1);
    wr(0, 8'h00);
    chk("R2 cleared", range, 0);

    // R3 R5 R6 R8 exhaustive sweep
    for (int m = 0; m < 8; m++)
      for (int c = 0; c < 64; c++) begin
        logic lp_b, st, ie, is, ee, es;
        int exp_loop, exp_irc, exp_erc, exp_ta;
        bit ext;
        lp_b = c[0]; st = c[1]; ie = c[2]; is = c[3]; ee = c[4]; es = c[5];
        wr(0, {es, ee, is, ie, 1'b0, lp_b, 2'(c)});
        mode = 3'(m); stop = st; #1;
        ext = (m == 1 || m == 3 || m == 4 || m == 5 || m == 7);
        exp_loop = (m == 0 || m == 1 || m == 4) ? 1 :
                   (m == 2 || m == 3 || m == 5) ? int'(!lp_b) : 0;
        exp_irc = int'(ie && (!st || is));
        exp_erc = st ? int'((ee && es) || ext) : int'(ee);
        exp_ta  = int'(m == 0 || m == 2 || m == 6);
        chk("R3 loop_en", loop_en, exp_loop);
        chk(st ? "R5 irc_en stop" : "R4 irc_en", irc_en, exp_irc);
        chk("R6 erc_en", erc_en, exp_erc);
        chk("R8 trim_act", trim_act, exp_ta);
      end

    // R4 R6 gated clocks
    mode = 0; stop = 0;
    wr(0, 8'h50);
    repeat (2) @(negedge clk);
    irc_cnt = 0; erc_cnt = 0;
    repeat (20) @(negedge clk);
    chk("R4 irc_clk runs", int'(irc_cnt > 0), 1);
    chk("R6 erc_clk runs", int'(erc_cnt > 0), 1);
    wr(0, 8'h00);
    repeat (2) @(negedge clk);
    irc_cnt = 0; erc_cnt = 0;
    repeat (20) @(negedge clk);
    chk("R4 irc_clk gated", irc_cnt, 0);
    chk("R6 erc_clk gated", erc_cnt, 0);
    stop = 1; mode = 3'd7;
    repeat (2) @(negedge clk);
    erc_cnt = 0;
    repeat (20) @(negedge clk);
    chk("R6 erc_clk stop ext", int'(erc_cnt > 0), 1);
    stop = 0; mode = 0;

    // R7 R8 trim and reset domains
    wr(1, 8'h3C);
    wr(2, 8'h01);
    chk("R8 trim_o", trim, 9'h079);
    wr(0, 8'hFF);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    rd_chk("R7 ctrl cleared", 0, 8'h00);
    rd_chk("R7 trim kept", 1, 8'h3C);
    rd_chk("R7 ftrim kept", 2, 8'h01);
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    @(negedge clk);
    rd_chk("R7 trim por", 1, 8'h80);
    rd_chk("R7 ftrim por", 2, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule